// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the slave side of a serial memory reached over SPI. A host selects it by driving the active-low chip select. It then clocks in an 8-bit instruction and, where the instruction needs one, a 16-bit address and data bytes. The block stores bytes in an internal array of 1 KB or 2 KB. Reads stream out sequentially. Writes are collected in a page buffer and committed when the chip select is released, and a busy timer then stands in for the programming time of a real device. A small protection unit keeps the status bits (busy, write-enable latch, two block-protect bits) and decides whether a write may proceed.

All serial inputs are oversampled by the system clock through two-stage synchronizers. The serial clock must therefore be several times slower than the system clock. SPI modes 0 and 3 both work, because only the edges of the serial clock matter and not its idle level.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset `sdoOe` is low and the status byte reads 0x00 (not busy, latch clear, no protection).
- R2: `sdoOe` is low while chip select is high and during instruction and address bits. It is high from the first output bit of a read or status read until chip select rises.
- R3: Input bits are taken on rising serial clock edges and output bits change on falling edges, in both mode 0 (clock idles low) and mode 3 (clock idles high).
- R4: Instruction 0x06 sets the write-enable latch (status bit 1) only if chip select rises right after its 8 bits. Instruction 0x04 clears the latch under the same rule.
- R5: Instruction 0x05 returns the status byte, MSB first, with bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = block protect and bits 7:4 = 0. The byte repeats for as long as the clock runs.
- R6: Instruction 0x03 is followed by a 16-bit address, of which only the low log2(size) bits count. Data then streams out from that address, incrementing, and wraps from the top address to 0.
- R7: Instruction 0x02 is followed by a 16-bit address and data bytes. The low 5 address bits advance and wrap within the 32-byte page. The page is committed on chip-select rise only if at least one byte was loaded and chip select rises on a byte boundary; otherwise nothing is written.
- R8: A commit sets busy (status bit 0) for BUSY_CYCLES system clocks. The write-enable latch clears when busy ends.
- R9: While busy, every instruction other than 0x05 is ignored until chip select rises.
- R10: Any opcode outside the six defined ones (0x01 to 0x06) makes the block ignore the rest of that selection.
- R11: Instruction 0x01 with one data byte, with the latch set and chip select rising right after 16 bits, loads data bits 3:2 into the block-protect bits and starts a busy period. Without the latch it has no effect.
- R12: Block protect 01 guards the top quarter of the array, 10 the top half and 11 all of it. A write into a guarded page, or with the latch clear, is discarded without a busy period and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
Every serial edge reaches the logic three system clocks late: two synchronizer stages plus one register. A new `sdo` bit therefore appears three clocks after a falling serial clock. The bench holds each serial clock phase for six clocks and samples `sdo` and `sdoOe` at the end of the low phase, just before the next rising edge. Busy rises three clocks after chip select rises. The bench checks that busy is still set a few hundred clocks before the period should end and that it is clear a short margin after the end, so neither check sits near a transition. Contents are checked through read transactions after the busy period ends, and status is checked through status reads.

// File: rtl/spiee_pkg.sv
`timescale 1ns/1ps
package spiee_pkg;
  localparam logic [7:0] OP_SETWEL = 8'h06;
  localparam logic [7:0] OP_CLRWEL = 8'h04;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] OP_RDMEM  = 8'h03;
  localparam logic [7:0] OP_WRMEM  = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_WDATA, PH_RDATA,
    PH_STAT, PH_SRIN, PH_SREND, PH_CMDEND, PH_SKIP
  } phase_e;

  typedef struct packed {
    logic addrShift;
    logic bufClear;
    logic bufWrite;
    logic loadMem;
    logic loadStat;
    logic shiftOut;
    logic commit;
  } dpStrobe_t;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startWrite;
    logic startSr;
  } protReq_t;
endpackage

// File: rtl/spiee_prot.sv
`timescale 1ns/1ps
module spiee_prot
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  protReq_t   req,
  input  logic [1:0] newBp,
  input  logic [1:0] addrTop,
  output logic       busy,
  output logic       wel,
  output logic [1:0] bp,
  output logic [7:0] statusByte,
  output logic       grantWrite,
  output logic       grantSr
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          guarded;

  always_comb begin
    unique case (bp)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = (addrTop == 2'b11);
      2'b10:   guarded = addrTop[1];
      default: guarded = 1'b1;
    endcase
  end

  assign grantWrite = wel && !busy && !guarded;
  assign grantSr    = wel && !busy;
  assign statusByte = {4'b0000, bp, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wel  <= 1'b0;
      bp   <= 2'b00;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (req.startWrite || req.startSr) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_CYCLES - 1);
      if (req.startSr) bp <= newBp;
    end else if (req.setWel) begin
      wel <= 1'b1;
    end else if (req.clrWel) begin
      wel <= 1'b0;
    end
  end
endmodule

// File: rtl/spiee_dpath.sv
`timescale 1ns/1ps
module spiee_dpath
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES  = 1024,
  parameter int PAGE_BYTES = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sck,
  input  logic                         csN,
  input  logic                         sdi,
  input  dpStrobe_t                    strb,
  input  logic [7:0]                   statusByte,
  output logic                         sckRise,
  output logic                         sckFall,
  output logic                         csFall,
  output logic                         csRise,
  output logic [7:0]                   rxNext,
  output logic [1:0]                   addrTop,
  output logic                         sdo,
  output logic                         sdoOe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [1:0] sckSync, csSync, sdiSync;
  logic       sckD, csD, sckS, csS;
  logic [7:0] rxShift, outShift;
  logic [15:0] addrQ;
  logic [PAGE_BYTES-1:0]   validVec;
  logic [PAGE_BYTES*8-1:0] dataVec;
  logic [7:0] mem [MEM_BYTES];
  logic [PW-1:0] wrOff;
  logic [AW-PW-1:0] pageSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSync <= 2'b00;
      csSync  <= 2'b11;
      sdiSync <= 2'b00;
      sckD    <= 1'b0;
      csD     <= 1'b1;
    end else begin
      sckSync <= {sckSync[0], sck};
      csSync  <= {csSync[0], csN};
      sdiSync <= {sdiSync[0], sdi};
      sckD    <= sckSync[1];
      csD     <= csSync[1];
    end
  end

  assign sckS    = sckSync[1];
  assign csS     = csSync[1];
  assign sckRise = sckS && !sckD;
  assign sckFall = !sckS && sckD;
  assign csFall  = !csS && csD;
  assign csRise  = csS && !csD;
  assign rxNext  = {rxShift[6:0], sdiSync[1]};
  assign wrOff   = addrQ[PW-1:0];
  assign pageSel = addrQ[AW-1:PW];
  assign addrTop = addrQ[AW-1:AW-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
    end else if (sckRise && !csS) begin
      rxShift <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
    end else if (strb.addrShift) begin
      addrQ <= {addrQ[7:0], rxNext};
    end else if (strb.loadMem) begin
      addrQ[AW-1:0] <= addrQ[AW-1:0] + 1'b1;
    end else if (strb.bufWrite) begin
      addrQ[PW-1:0] <= addrQ[PW-1:0] + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page
    logic       vQ;
    logic [7:0] dQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vQ <= 1'b0;
        dQ <= '0;
      end else if (strb.bufClear) begin
        vQ <= 1'b0;
      end else if (strb.bufWrite && wrOff == PW'(g)) begin
        vQ <= 1'b1;
        dQ <= rxNext;
      end
    end
    assign validVec[g]        = vQ;
    assign dataVec[g*8 +: 8]  = dQ;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (validVec[i]) mem[{pageSel, PW'(i)}] <= dataVec[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outShift <= '0;
      sdoOe    <= 1'b0;
    end else begin
      if (strb.loadMem)       outShift <= mem[addrQ[AW-1:0]];
      else if (strb.loadStat) outShift <= statusByte;
      else if (strb.shiftOut) outShift <= {outShift[6:0], 1'b0};
      if (csS)                                 sdoOe <= 1'b0;
      else if (strb.loadMem || strb.loadStat)  sdoOe <= 1'b1;
    end
  end

  assign sdo = outShift[7];
endmodule

// File: rtl/spiee_ctrl.sv
`timescale 1ns/1ps
module spiee_ctrl
  import spiee_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       csFall,
  input  logic       csRise,
  input  logic [7:0] rxNext,
  input  logic       busy,
  input  logic       grantWrite,
  input  logic       grantSr,
  output dpStrobe_t  strb,
  output protReq_t   preq,
  output logic [1:0] newBp
);
  phase_e     phase;
  logic [2:0] bitIdx;
  logic       addrSecond, isRead, gotData, isSet;
  logic       byteDone;

  assign byteDone = sckRise && (bitIdx == 3'd7);

  always_comb begin
    strb = '0;
    preq = '0;
    if (csRise) begin
      unique case (phase)
        PH_CMDEND: begin
          preq.setWel = isSet;
          preq.clrWel = !isSet;
        end
        PH_SREND: preq.startSr = grantSr;
        PH_WDATA: begin
          if (bitIdx == 3'd0 && gotData && grantWrite) begin
            preq.startWrite = 1'b1;
            strb.commit     = 1'b1;
          end
        end
        default: ;
      endcase
    end else begin
      unique case (phase)
        PH_ADDR: begin
          strb.addrShift = byteDone;
          strb.bufClear  = byteDone && addrSecond && !isRead;
        end
        PH_WDATA: strb.bufWrite = byteDone;
        PH_RDATA: begin
          strb.loadMem  = sckFall && bitIdx == 3'd0;
          strb.shiftOut = sckFall && bitIdx != 3'd0;
        end
        PH_STAT: begin
          strb.loadStat = sckFall && bitIdx == 3'd0;
          strb.shiftOut = sckFall && bitIdx != 3'd0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bitIdx     <= '0;
      addrSecond <= 1'b0;
      isRead     <= 1'b0;
      gotData    <= 1'b0;
      isSet      <= 1'b0;
      newBp      <= 2'b00;
    end else if (csRise) begin
      phase <= PH_IDLE;
    end else if (csFall) begin
      phase  <= PH_OPC;
      bitIdx <= '0;
    end else if (sckRise && phase != PH_IDLE) begin
      bitIdx <= bitIdx + 1'b1;
      unique case (phase)
        PH_OPC: if (byteDone) begin
          if (busy && rxNext != OP_RDSTAT) phase <= PH_SKIP;
          else begin
            unique case (rxNext)
              OP_SETWEL: begin phase <= PH_CMDEND; isSet <= 1'b1; end
              OP_CLRWEL: begin phase <= PH_CMDEND; isSet <= 1'b0; end
              OP_RDSTAT: phase <= PH_STAT;
              OP_WRSTAT: phase <= PH_SRIN;
              OP_RDMEM:  begin phase <= PH_ADDR; isRead <= 1'b1; addrSecond <= 1'b0; end
              OP_WRMEM:  begin phase <= PH_ADDR; isRead <= 1'b0; addrSecond <= 1'b0; end
              default:   phase <= PH_SKIP;
            endcase
          end
        end
        PH_ADDR: if (byteDone) begin
          if (addrSecond) begin
            phase   <= isRead ? PH_RDATA : PH_WDATA;
            gotData <= 1'b0;
          end else begin
            addrSecond <= 1'b1;
          end
        end
        PH_WDATA: if (byteDone) gotData <= 1'b1;
        PH_SRIN: if (byteDone) begin
          phase <= PH_SREND;
          newBp <= rxNext[3:2];
        end
        PH_CMDEND, PH_SREND: phase <= PH_SKIP;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_engine.sv
`timescale 1ns/1ps
module spi_eeprom_engine
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csN,
  input  logic sdi,
  output logic sdo,
  output logic sdoOe
);
  dpStrobe_t  strb;
  protReq_t   preq;
  logic       sckRise, sckFall, csFall, csRise;
  logic [7:0] rxNext, statusByte;
  logic [1:0] addrTop, newBp, bpW;
  logic       busyW, welW, grantWrite, grantSr;

  spiee_dpath #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csN(csN), .sdi(sdi),
    .strb(strb), .statusByte(statusByte),
    .sckRise(sckRise), .sckFall(sckFall), .csFall(csFall), .csRise(csRise),
    .rxNext(rxNext), .addrTop(addrTop), .sdo(sdo), .sdoOe(sdoOe)
  );

  spiee_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sckRise(sckRise), .sckFall(sckFall),
    .csFall(csFall), .csRise(csRise), .rxNext(rxNext), .busy(busyW),
    .grantWrite(grantWrite), .grantSr(grantSr),
    .strb(strb), .preq(preq), .newBp(newBp)
  );

  spiee_prot #(.MEM_BYTES(MEM_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_prot (
    .clk(clk), .rst_n(rst_n), .req(preq), .newBp(newBp), .addrTop(addrTop),
    .busy(busyW), .wel(welW), .bp(bpW), .statusByte(statusByte),
    .grantWrite(grantWrite), .grantSr(grantSr)
  );
endmodule

// File: rtl/spi_eeprom_engine_chk.sv
`timescale 1ns/1ps
module spi_eeprom_engine_chk #(
  parameter int BUSY_CYCLES = 1000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       csN,
  input logic       sdoOe,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp
);
  logic [3:0] csHiRun;
  int unsigned busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csHiRun <= '0;
      busyRun <= 0;
    end else begin
      csHiRun <= !csN ? 4'd0 : (csHiRun == 4'hF ? csHiRun : csHiRun + 1'b1);
      busyRun <= busy ? busyRun + 1 : 0;
    end
  end

  p_oe_off_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csHiRun >= 4'd4) |-> !sdoOe);

  p_busy_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyRun < BUSY_CYCLES));

  p_wel_drop_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  p_no_wel_set_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));

  p_bp_only_on_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(busy));
endmodule

bind spi_eeprom_engine spi_eeprom_engine_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .csN(csN), .sdoOe(sdoOe),
  .busy(busyW), .wel(welW), .bp(bpW)
);

// File: tb/spi_eeprom_engine_tb.sv
`timescale 1ns/1ps
module spi_eeprom_engine_tb;
  localparam int MEM  = 1024;
  localparam int BUSY = 2000;
  localparam int HALF = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csN = 1'b1, sdi = 1'b0;
  logic sdo, sdoOe;
  logic mode3 = 1'b0;
  int nChecks = 0, nFail = 0;
  int cyc = 0;
  logic done = 1'b0;
  logic oeAny, oeAll;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_eeprom_engine #(.MEM_BYTES(MEM), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csN(csN), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    oeAny = 1'b0; oeAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (mode3) sck = 1'b0;
      sdi = tx[i];
      #HALF;
      rx[i] = sdo;
      oeAny = oeAny | sdoOe;
      oeAll = oeAll & sdoOe;
      sck = 1'b1;
      #HALF;
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic startCs();
    sck = mode3;
    #HALF;
    csN = 1'b0;
    #HALF;
  endtask

  task automatic endCs();
    #HALF;
    csN = 1'b1;
    #(4*HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    startCs(); xfer(op, r); endCs();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    startCs(); xfer(8'h05, r); xfer(8'h00, st); endCs();
  endtask

  task automatic memWrite(input logic [15:0] addr, input int n);
    logic [7:0] r;
    startCs(); xfer(8'h02, r); xfer(addr[15:8], r); xfer(addr[7:0], r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r);
    endCs();
  endtask

  task automatic memRead(input logic [15:0] addr, input int n, output logic addrOe, output logic dataOe);
    logic [7:0] r;
    startCs(); xfer(8'h03, r); xfer(addr[15:8], r); addrOe = oeAny;
    xfer(addr[7:0], r); addrOe = addrOe | oeAny;
    dataOe = 1'b1;
    for (int i = 0; i < n; i++) begin xfer(8'h00, rbuf[i]); dataOe = dataOe & oeAll; end
    endCs();
  endtask

  task automatic waitIdle();
    repeat (BUSY + 50) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] st;
    chk("R1", "oe after reset", sdoOe, 1'b0);
    startCs();
    xfer(8'h05, st);
    chk("R2", "oe during opcode", oeAny, 1'b0);
    xfer(8'h00, st);
    chk("R2", "oe during status bits", oeAll, 1'b1);
    endCs();
    chk("R1", "status after reset", st, 8'h00);
    chk("R2", "oe after cs high", sdoOe, 1'b0);
  endtask

  task automatic t_latch();
    logic [7:0] st, st2, r;
    cmd1(8'h06);
    startCs(); xfer(8'h05, r); xfer(8'h00, st); xfer(8'h00, st2); endCs();
    chk("R4", "latch set by 0x06", st, 8'h02);
    chk("R5", "status repeats", st2, 8'h02);
    cmd1(8'h04);
    rdsr(st);
    chk("R4", "latch cleared by 0x04", st, 8'h00);
    startCs(); xfer(8'h06, r); xfer(8'h00, r); endCs();
    rdsr(st);
    chk("R4", "0x06 with extra bits ignored", st, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] st;
    logic aOe, dOe;
    int c0;
    cmd1(8'h06);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    memWrite(16'h0010, 4);
    c0 = cyc - 4*HALF/5;
    rdsr(st);
    chk("R8", "busy and latch after commit", st, 8'h03);
    cmd1(8'h06);
    memRead(16'h0010, 1, aOe, dOe);
    chk("R9", "read ignored while busy", dOe, 1'b0);
    while (cyc < c0 + BUSY - 300) @(negedge clk);
    rdsr(st);
    chk("R8", "still busy near end", st[0], 1'b1);
    while (cyc < c0 + BUSY + 50) @(negedge clk);
    rdsr(st);
    chk("R8", "idle, latch cleared", st, 8'h00);
    chk("R9", "0x06 during busy had no effect", st[1], 1'b0);
    memRead(16'h0010, 4, aOe, dOe);
    chk("R2", "oe during address", aOe, 1'b0);
    chk("R2", "oe during data", dOe, 1'b1);
    for (int i = 0; i < 4; i++) chk("R6", "sequential read", rbuf[i], wbuf[i]);
    memRead(16'hFC12, 1, aOe, dOe);
    chk("R6", "upper address bits ignored", rbuf[0], 8'hC3);
  endtask

  task automatic t_page_wrap_mode3();
    logic aOe, dOe;
    mode3 = 1'b1;
    cmd1(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    memWrite(16'h003E, 4);
    waitIdle();
    memRead(16'h003E, 2, aOe, dOe);
    chk("R3", "mode 3 page end byte", rbuf[0], 8'h11);
    chk("R7", "page end byte 2", rbuf[1], 8'h22);
    memRead(16'h0020, 2, aOe, dOe);
    chk("R7", "wrapped to page start", rbuf[0], 8'h33);
    chk("R7", "wrapped second", rbuf[1], 8'h44);
    mode3 = 1'b0;
  endtask

  task automatic t_partial();
    logic [7:0] st, r;
    logic aOe, dOe;
    cmd1(8'h06);
    startCs(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h99, r);
    for (int i = 0; i < 3; i++) begin sdi = 1'b1; #HALF; sck = 1'b1; #HALF; sck = 1'b0; end
    endCs();
    rdsr(st);
    chk("R7", "partial byte: no busy, latch kept", st, 8'h02);
    cmd1(8'h04);
    memRead(16'h0010, 1, aOe, dOe);
    chk("R7", "partial write discarded", rbuf[0], 8'hA1);
  endtask

  task automatic t_read_wrap();
    logic aOe, dOe;
    cmd1(8'h06); wbuf[0] = 8'h5A; memWrite(16'h03FF, 1); waitIdle();
    cmd1(8'h06); wbuf[0] = 8'hC3; memWrite(16'h0000, 1); waitIdle();
    memRead(16'h03FF, 2, aOe, dOe);
    chk("R6", "top address", rbuf[0], 8'h5A);
    chk("R6", "wrap to 0", rbuf[1], 8'hC3);
  endtask

  task automatic t_unknown();
    logic [7:0] st, r;
    startCs(); xfer(8'hAB, r); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h00, r);
    chk("R10", "no output after bad opcode", oeAny, 1'b0);
    endCs();
    startCs(); xfer(8'hFF, r); xfer(8'h06, r); endCs();
    rdsr(st);
    chk("R10", "later opcode ignored", st, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] st, r;
    logic aOe, dOe;
    startCs(); xfer(8'h01, r); xfer(8'h0C, r); endCs();
    rdsr(st);
    chk("R11", "status write without latch", st, 8'h00);
    cmd1(8'h06);
    startCs(); xfer(8'h01, r); xfer(8'h04, r); endCs();
    rdsr(st);
    chk("R11", "status write starts busy", st, 8'h07);
    waitIdle();
    rdsr(st);
    chk("R11", "quarter protect set", st, 8'h04);
    cmd1(8'h06); wbuf[0] = 8'hEE; memWrite(16'h03FF, 1);
    rdsr(st);
    chk("R12", "guarded write: no busy, latch kept", st, 8'h06);
    memRead(16'h03FF, 1, aOe, dOe);
    chk("R12", "guarded quarter unchanged", rbuf[0], 8'h5A);
    wbuf[0] = 8'h77; memWrite(16'h02FF, 1);
    rdsr(st);
    chk("R12", "unguarded write busy", st, 8'h07);
    waitIdle();
    memRead(16'h02FF, 1, aOe, dOe);
    chk("R12", "unguarded write stored", rbuf[0], 8'h77);
    cmd1(8'h06);
    startCs(); xfer(8'h01, r); xfer(8'h08, r); endCs(); waitIdle();
    cmd1(8'h06); wbuf[0] = 8'h12; memWrite(16'h02FF, 1);
    rdsr(st);
    chk("R12", "half protect: write refused", st, 8'h0A);
    memRead(16'h02FF, 1, aOe, dOe);
    chk("R12", "half protect unchanged", rbuf[0], 8'h77);
    startCs(); xfer(8'h01, r); xfer(8'hFF, r); endCs(); waitIdle();
    rdsr(st);
    chk("R11", "only protect bits written", st, 8'h0C);
    cmd1(8'h06); wbuf[0] = 8'h55; memWrite(16'h0010, 1);
    memRead(16'h0010, 1, aOe, dOe);
    chk("R12", "full protect unchanged", rbuf[0], 8'hA1);
    startCs(); xfer(8'h01, r); xfer(8'h00, r); endCs(); waitIdle();
    memWrite(16'h0010, 1);
    rdsr(st);
    chk("R12", "write without latch: no busy", st, 8'h00);
    memRead(16'h0010, 1, aOe, dOe);
    chk("R12", "write without latch discarded", rbuf[0], 8'hA1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_write_read();
    t_page_wrap_mode3();
    t_partial();
    t_read_wrap();
    t_unknown();
    t_protect();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule